// File: doc/BRIEF.md
# Pin Multiplexer Port Controller

This block controls one bank of I/O pins. For every pin it decides whether the general-purpose I/O logic or one of four peripheral functions drives the pad. It also holds that pin's output enable, output data, open-drain, pull-up, pull-down, Schmitt-disable and drive-strength settings, plus an interrupt-enable mask. Software reaches these settings through a single-cycle register port. Each per-pin control sits in a set/clear/status triple: a written 1 sets or clears the pin's bit, and a written 0 leaves it alone.

The peripheral choice is a two-bit code held across two plain select registers. Drive strength is packed two bits per pin across two registers. Pull-up and pull-down interlock in hardware. Any ownership or select change disables the interrupt of each pin it touches, in the same write. Input pin levels pass through a two-flop synchronizer before they can be read.

Top module: `pinmux_bank`

## Requirements
- R1: After reset, every pin is owned by the I/O logic, pull-up is set on all pins, and output enable, output data, open-drain, pull-down, both select registers, both drive registers, Schmitt-disable and interrupt enable are all zero.
- R2: A write of 1s to word address 0 hands those pins to the I/O logic. A write to address 1 hands them to their peripheral function. Address 2 reads the ownership mask, where 1 means owned by the I/O logic.
- R3: Output enable, output data and open-drain use set/clear/status addresses 3/4/5, 6/7/8 and 9/10/11. A 1 bit sets or clears that pin's bit, and a 0 bit leaves it unchanged.
- R4: Select registers sit at address 21 (low bit) and address 22 (high bit) and are read/write. Pin n's code on `per_sel_o[2n+1:2n]` is {high[n], low[n]}, giving 0 = function A, 1 = B, 2 = C and 3 = D.
- R5: Pull-up uses set/clear/status 12/13/14 and pull-down uses 15/16/17. Setting pull-up on a pin clears its pull-down in the same write, and the reverse also holds, so both are never set on one pin.
- R6: Drive strength is two bits per pin. Pins 0–15 sit at bits 2n+1:2n of address 24. Pins 16–31 sit at bits 2(n−16)+1:2(n−16) of address 25. Both registers are read/write, and `drv_o[2n+1:2n]` carries pin n's field.
- R7: `pad_oe_o[n]` is high only when pin n is owned by the I/O logic and its output enable is set. `pad_out_o[n]` is additionally gated by the output-data bit.
- R8: Schmitt-disable is a read/write mask at address 23 and drives `schmitt_dis_o`.
- R9: Interrupt enable uses set/clear/status 18/19/20. A write to address 0 or 1 clears the enable of every pin written with 1. A write to address 21 or 22 clears the enable of every pin whose select bit changes.
- R10: Address 26 returns `pad_in_i` after two rising clock edges of synchronization.
- R11: Writes to status addresses, address 26 or unused addresses change nothing. Reads of unused addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access valid |
| we_i | input | 1 | Write strobe, qualified by req_i |
| addr_i | input | 5 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| pad_in_i | input | 32 | Raw pin levels |
| gpio_own_o | output | 32 | 1 = pin owned by the I/O logic |
| per_sel_o | output | 64 | Two-bit peripheral code per pin |
| pad_oe_o | output | 32 | Pad output enable |
| pad_out_o | output | 32 | Pad output data |
| od_o | output | 32 | Open-drain enable |
| pu_o | output | 32 | Pull-up enable |
| pd_o | output | 32 | Pull-down enable |
| schmitt_dis_o | output | 32 | Schmitt trigger disable |
| drv_o | output | 64 | Two-bit drive strength per pin |
| irq_en_o | output | 32 | Interrupt enable per pin |

## Verification
Two things fall in the same clock edge. A function change (an ownership write or a select write) clears the interrupt enable of the pins it touches in that very write. A pull set clears the opposite pull in the same way. The bench first sets every interrupt enable and pull. It then issues single writes to ownership, select and pull addresses, and reads the status registers right after that edge. Each result must show both the requested change and the interlock clear, with no intermediate state.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  localparam int NPIN   = 32;
  localparam int ADDR_W = 5;
  localparam int NPAIR  = 7;
  // pair index; set/clr/status addresses are 3p, 3p+1, 3p+2
  localparam int P_OWN = 0;
  localparam int P_OE  = 1;
  localparam int P_OUT = 2;
  localparam int P_OD  = 3;
  localparam int P_PU  = 4;
  localparam int P_PD  = 5;
  localparam int P_IRQ = 6;
  localparam int A_SEL_LO  = 21;
  localparam int A_SEL_HI  = 22;
  localparam int A_SCHMITT = 23;
  localparam int A_DRV_LO  = 24;
  localparam int A_DRV_HI  = 25;
  localparam int A_LEVEL   = 26;

  function automatic int set_addr(int p);
    return 3 * p;
  endfunction
  function automatic int clr_addr(int p);
    return 3 * p + 1;
  endfunction
  function automatic int stat_addr(int p);
    return 3 * p + 2;
  endfunction
endpackage

// File: rtl/pinmux_pair.sv
module pinmux_pair #(
  parameter int W = 32,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  // clear wins over set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= RST;
    else         q_o <= (q_o | set_i) & ~clr_i;
  end
endmodule

// File: rtl/pinmux_sync.sv
module pinmux_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      q_o  <= '0;
    end else begin
      s1_q <= d_i;
      q_o  <= s1_q;
    end
  end
endmodule

// File: rtl/pinmux_bank.sv
module pinmux_bank
  import pinmux_pkg::*;
#(
  parameter int N  = NPIN,
  parameter int AW = ADDR_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_i,
  input  logic           we_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [N-1:0]   wdata_i,
  output logic [N-1:0]   rdata_o,
  input  logic [N-1:0]   pad_in_i,
  output logic [N-1:0]   gpio_own_o,
  output logic [2*N-1:0] per_sel_o,
  output logic [N-1:0]   pad_oe_o,
  output logic [N-1:0]   pad_out_o,
  output logic [N-1:0]   od_o,
  output logic [N-1:0]   pu_o,
  output logic [N-1:0]   pd_o,
  output logic [N-1:0]   schmitt_dis_o,
  output logic [2*N-1:0] drv_o,
  output logic [N-1:0]   irq_en_o
);
  localparam int HALF = N / 2;

  logic                       wr;
  logic [NPAIR-1:0][N-1:0]    set_v, clr_v, q_v;
  logic [N-1:0]               sel_lo_q, sel_hi_q, schmitt_q, level_q;
  logic [N-1:0]               drv_lo_q, drv_hi_q;
  logic [N-1:0]               reconf;

  assign wr = req_i & we_i;

  function automatic logic hit(logic [AW-1:0] a, int target);
    return a == AW'(target);
  endfunction

  // pins whose function is being changed by this write
  always_comb begin
    reconf = '0;
    if (wr && (hit(addr_i, set_addr(P_OWN)) || hit(addr_i, clr_addr(P_OWN))))
      reconf = wdata_i;
    else if (wr && hit(addr_i, A_SEL_LO))
      reconf = wdata_i ^ sel_lo_q;
    else if (wr && hit(addr_i, A_SEL_HI))
      reconf = wdata_i ^ sel_hi_q;
  end

  always_comb begin
    for (int p = 0; p < NPAIR; p++) begin
      set_v[p] = (wr && hit(addr_i, set_addr(p))) ? wdata_i : '0;
      clr_v[p] = (wr && hit(addr_i, clr_addr(p))) ? wdata_i : '0;
    end
    clr_v[P_PU]  = clr_v[P_PU] | set_v[P_PD];
    clr_v[P_PD]  = clr_v[P_PD] | set_v[P_PU];
    clr_v[P_IRQ] = clr_v[P_IRQ] | reconf;
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    pinmux_pair #(
      .W  (N),
      .RST((p == P_OWN || p == P_PU) ? {N{1'b1}} : {N{1'b0}})
    ) u_pair (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (set_v[p]),
      .clr_i (clr_v[p]),
      .q_o   (q_v[p])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_lo_q  <= '0;
      sel_hi_q  <= '0;
      schmitt_q <= '0;
      drv_lo_q  <= '0;
      drv_hi_q  <= '0;
    end else if (wr) begin
      if (hit(addr_i, A_SEL_LO))  sel_lo_q  <= wdata_i;
      if (hit(addr_i, A_SEL_HI))  sel_hi_q  <= wdata_i;
      if (hit(addr_i, A_SCHMITT)) schmitt_q <= wdata_i;
      if (hit(addr_i, A_DRV_LO))  drv_lo_q  <= wdata_i;
      if (hit(addr_i, A_DRV_HI))  drv_hi_q  <= wdata_i;
    end
  end

  pinmux_sync #(.W(N)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (level_q)
  );

  always_comb begin
    rdata_o = '0;
    for (int p = 0; p < NPAIR; p++)
      if (hit(addr_i, stat_addr(p))) rdata_o = q_v[p];
    if (hit(addr_i, A_SEL_LO))  rdata_o = sel_lo_q;
    if (hit(addr_i, A_SEL_HI))  rdata_o = sel_hi_q;
    if (hit(addr_i, A_SCHMITT)) rdata_o = schmitt_q;
    if (hit(addr_i, A_DRV_LO))  rdata_o = drv_lo_q;
    if (hit(addr_i, A_DRV_HI))  rdata_o = drv_hi_q;
    if (hit(addr_i, A_LEVEL))   rdata_o = level_q;
  end

  for (genvar n = 0; n < N; n++) begin : g_sel
    assign per_sel_o[2*n +: 2] = {sel_hi_q[n], sel_lo_q[n]};
  end

  // low half of the pins from the first drive register, high half from the second
  assign drv_o = {drv_hi_q[2*HALF-1:0], drv_lo_q[2*HALF-1:0]};

  assign gpio_own_o    = q_v[P_OWN];
  assign pad_oe_o      = q_v[P_OWN] & q_v[P_OE];
  assign pad_out_o     = q_v[P_OWN] & q_v[P_OE] & q_v[P_OUT];
  assign od_o          = q_v[P_OD];
  assign pu_o          = q_v[P_PU];
  assign pd_o          = q_v[P_PD];
  assign schmitt_dis_o = schmitt_q;
  assign irq_en_o      = q_v[P_IRQ];
endmodule

// File: rtl/pinmux_bank_chk.sv
module pinmux_bank_chk #(
  parameter int N  = 32,
  parameter int AW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic [N-1:0]  wdata_i,
  input logic [N-1:0]  rdata_o,
  input logic [N-1:0]  gpio_own_o,
  input logic [N-1:0]  pad_oe_o,
  input logic [N-1:0]  pu_o,
  input logic [N-1:0]  pd_o,
  input logic [N-1:0]  irq_en_o
);
  // R5 pulls never both on
  a_r5_pull_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pu_o & pd_o) == '0);

  // R7 no pad drive from a peripheral-owned pin's I/O logic
  a_r7_oe_needs_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & ~gpio_own_o) == '0);

  // R2 ownership set write takes effect next cycle
  a_r2_own_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == AW'(0)) |=>
      ((gpio_own_o & $past(wdata_i)) == $past(wdata_i)));

  // R9 ownership hand-off disables the interrupt of written pins
  a_r9_irq_off_on_handoff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == AW'(1)) |=> ((irq_en_o & $past(wdata_i)) == '0));

  // R11 write to pull-up status address leaves pulls alone
  a_r11_status_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == AW'(14)) |=> ($stable(pu_o) && $stable(pd_o)));
endmodule

bind pinmux_bank pinmux_bank_chk #(.N(N), .AW(AW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .gpio_own_o(gpio_own_o),
  .pad_oe_o  (pad_oe_o),
  .pu_o      (pu_o),
  .pd_o      (pd_o),
  .irq_en_o  (irq_en_o)
);

// File: tb/pinmux_bank_tb.sv
module pinmux_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o, pad_in_i = '0;
  logic [31:0] gpio_own_o, pad_oe_o, pad_out_o, od_o, pu_o, pd_o, schmitt_dis_o, irq_en_o;
  logic [63:0] per_sel_o, drv_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pinmux_bank u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pad_in_i(pad_in_i),
    .gpio_own_o(gpio_own_o), .per_sel_o(per_sel_o), .pad_oe_o(pad_oe_o),
    .pad_out_o(pad_out_o), .od_o(od_o), .pu_o(pu_o), .pd_o(pd_o),
    .schmitt_dis_o(schmitt_dis_o), .drv_o(drv_o), .irq_en_o(irq_en_o)
  );

  // {write addr, write data, read addr, expected read}
  localparam logic [73:0] VEC [NV] = '{
    {5'd3,  32'h0000_00FF, 5'd5,  32'h0000_00FF}, // R3 oe set
    {5'd4,  32'h0000_000F, 5'd5,  32'h0000_00F0}, // R3 oe clear
    {5'd6,  32'hA5A5_A5A5, 5'd8,  32'hA5A5_A5A5}, // R3 out set
    {5'd7,  32'h0000_FFFF, 5'd8,  32'hA5A5_0000}, // R3 out clear
    {5'd9,  32'h8000_0001, 5'd11, 32'h8000_0001}, // R3 open-drain set
    {5'd15, 32'h0000_000F, 5'd14, 32'hFFFF_FFF0}, // R5 pd set clears pu
    {5'd12, 32'h0000_0003, 5'd17, 32'h0000_000C}, // R5 pu set clears pd
    {5'd1,  32'h0000_FF00, 5'd2,  32'hFFFF_00FF}, // R2 hand to peripheral
    {5'd21, 32'h0000_AA00, 5'd21, 32'h0000_AA00}, // R4 select low rw
    {5'd25, 32'hC000_0003, 5'd25, 32'hC000_0003}, // R6 drive high rw
    {5'd5,  32'hFFFF_FFFF, 5'd5,  32'h0000_00F0}, // R11 status write ignored
    {5'd30, 32'hFFFF_FFFF, 5'd14, 32'hFFFF_FFF3}  // R11 unused write ignored
  };
  localparam int VREQ [NV] = '{3, 3, 3, 3, 3, 5, 5, 2, 4, 6, 11, 11};

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    rd(5'd2, r);  check("R1 own", r, 32'hFFFF_FFFF);
    rd(5'd14, r); check("R1 pull-up", r, 32'hFFFF_FFFF);
    rd(5'd5, r);  check("R1 oe", r, 0);
    check("R1 pads/sel/drv/irq", {pad_oe_o | pd_o | irq_en_o | schmitt_dis_o, per_sel_o[31:0] | drv_o[31:0]}, 0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][73:69], VEC[i][68:37]);
      rd(VEC[i][36:32], r);
      check($sformatf("R%0d vector %0d", VREQ[i], i), r, VEC[i][31:0]);
    end

    // R7 pad gating: own=FFFF00FF
    wr(5'd6, 32'h0000_00FF);
    wr(5'd3, 32'h0000_FF00);
    @(negedge clk_i);
    check("R7 pad_oe", pad_oe_o, 32'h0000_00F0);
    check("R7 pad_out", pad_out_o, 32'h0000_00F0);
    check("R3 od_o", od_o, 32'h8000_0001);

    // R4 codes for pins 8..11: A,B,C,D
    wr(5'd22, 32'h0000_CC00);
    @(negedge clk_i);
    check("R4 per_sel pins 8-11", per_sel_o[23:16], 8'hE4);

    // R6 drive packing
    wr(5'd24, 32'h0000_0004);
    @(negedge clk_i);
    check("R6 pin1", drv_o[3:2], 2'd1);
    check("R6 pin16/17/31", {drv_o[33:32], drv_o[35:34], drv_o[63:62]}, 6'b11_00_11);

    // R8 schmitt
    wr(5'd23, 32'h0F0F_0000);
    @(negedge clk_i);
    check("R8 schmitt", schmitt_dis_o, 32'h0F0F_0000);

    // R9 interrupt enable and reconfiguration
    wr(5'd18, 32'hFFFF_FFFF);
    wr(5'd0, 32'h0000_0001);
    rd(5'd20, r); check("R9 own write clears irq", r, 32'hFFFF_FFFE);
    wr(5'd21, 32'h0001_AA00);
    rd(5'd20, r); check("R9 select change clears irq", r, 32'hFFFE_FFFE);
    wr(5'd19, 32'h8000_0000);
    rd(5'd20, r); check("R9 irq clear", r, 32'h7FFE_FFFE);

    // R11 unused read
    rd(5'd30, r); check("R11 unused read", r, 0);

    // R10 two-edge synchronizer
    @(negedge clk_i);
    addr_i = 5'd26;
    pad_in_i = 32'h1234_5678;
    @(posedge clk_i);
    @(negedge clk_i);
    #1 check("R10 after one edge", rdata_o, 0);
    @(posedge clk_i);
    @(negedge clk_i);
    #1 check("R10 after two edges", rdata_o, 32'h1234_5678);

    finish_run();
  end
endmodule